// File: doc/BRIEF.md
# Overlay Character Code Resolver

This block works out which font code belongs in each cell of a text overlay of 24 columns by 12 rows. Every display row owns a pointer into a shared table of predefined text lines (64 lines of 24 entries each). The table entry found at pointer plus column either names a font code outright or marks the cell as variable text. A variable cell takes its code and an attribute bit from a small display RAM. The RAM holds no per-cell address: slots are handed out one after another as variable cells are visited in raster order, and the sequence restarts at slot 0 on every frame.

A pixel engine issues one row/column request per cell, in raster order, and pulses a frame-start strobe before the first cell of each frame. Two clock cycles after each request the block returns a 7-bit font code, an attribute bit and a valid flag. The pointers, the line table and the display RAM sit inside the block and are loaded through a simple write port.

Top module: `cr_code_resolver`

## Requirements
- R1: After reset every pointer, line-table entry and RAM word is zero and out_valid is low, so a request for row 0, column 0 returns code 0 with attribute 0.
- R2: A write with wr_en high stores into the line table when wr_sel is 0 (address below 1536, data bits 7:0), into the display RAM when wr_sel is 1 (address below 176, data bits 7:0), or into a row pointer when wr_sel is 2 (row index below 12, data bits 10:0). wr_sel 3, or wr_en low, changes nothing.
- R3: A cell's table address is its row pointer plus its column, so pointing a row at 24*(k-1) shows line k of the table.
- R4: A table entry with bit 7 clear is a direct cell: out_code is entry bits 6:0 and out_attr is 0.
- R5: A table entry with bit 7 set is a variable cell: out_code is bits 6:0 and out_attr is bit 7 of the display RAM word at the current slot, and the slot advances by one.
- R6: A frame_start pulse returns the slot sequence to 0, so the first variable cell after it reads RAM word 0.
- R7: Once 176 slots are used in a frame, further variable cells return the blank code 0x20 with attribute 0 and the slot stays at 176.
- R8: A request with row below 12 and column below 24, presented in cycle t, gives out_valid high in cycle t+2; any other request gives no output and no slot.
- R9: A table address of 1536 or more returns the blank code 0x20 with attribute 0 and uses no slot.
- R10: Direct cells never use a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 line table, 1 display RAM, 2 row pointer, 3 none |
| wr_addr | input | 11 | Write address or row index |
| wr_data | input | 11 | Write data |
| frame_start | input | 1 | Restart the slot sequence |
| req_valid | input | 1 | Cell request strobe |
| req_row | input | 4 | Requested row |
| req_col | input | 5 | Requested column |
| out_valid | output | 1 | Result valid |
| out_code | output | 7 | Resolved font code |
| out_attr | output | 1 | Attribute bit of the cell |

## Verification
The hardest state to reach is slot exhaustion, which needs more than 176 variable cells in a single frame while the random tables give about one in four. The bench loads the last table line with redirect entries only and points all twelve rows at it, so a full frame of 288 cells runs through all 176 slots and then 112 blank cells. Random tables and random out-of-range requests then check that the slot sequence is kept and restarts on each frame.

// File: rtl/cr_pkg.sv
package cr_pkg;

  typedef enum logic [1:0] {
    WSEL_TABLE = 2'd0,
    WSEL_RAM   = 2'd1,
    WSEL_PTR   = 2'd2,
    WSEL_NONE  = 2'd3
  } wsel_e;

  // line-table entry: redir set means take the code from the display RAM
  typedef struct packed {
    logic       redir;
    logic [6:0] code;
  } entry_t;

  // display RAM word and block output
  typedef struct packed {
    logic       attr;
    logic [6:0] code;
  } cell_t;

endpackage

// File: rtl/cr_ptr_bank.sv
module cr_ptr_bank #(
  parameter int ROWS   = 12,
  parameter int ADDR_W = 11,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  cr_pkg::wsel_e     wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              row_ok,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [COL_W-1:0]  rd_col,
  output logic [ADDR_W:0]   rd_addr
);
  localparam logic [ADDR_W-1:0] ROW_LIMIT = ADDR_W'(ROWS);

  logic [ADDR_W-1:0] ptr_q [ROWS];
  logic              sel_ok;
  logic [ADDR_W-1:0] base;

  assign sel_ok = wr_en && (wr_sel == cr_pkg::WSEL_PTR) && (wr_addr < ROW_LIMIT);

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic we;
    assign we = sel_ok && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[g] <= '0;
      end else if (we) begin
        ptr_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    base = '0;
    if (row_ok) begin
      base = ptr_q[rd_row];
    end
  end

  assign rd_addr = (ADDR_W+1)'(base) + (ADDR_W+1)'(rd_col);

endmodule

// File: rtl/cr_line_table.sv
module cr_line_table #(
  parameter int DEPTH  = 1536,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  cr_pkg::wsel_e     wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output cr_pkg::entry_t    rd_entry
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

  cr_pkg::entry_t mem_q [DEPTH];
  logic           we;

  assign we = wr_en && (wr_sel == cr_pkg::WSEL_TABLE) && (wr_addr < LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= '0;
      end
    end else if (we) begin
      mem_q[wr_addr] <= cr_pkg::entry_t'(wr_data);
    end
  end

  always_comb begin
    rd_entry = '0;
    if (rd_addr < LIMIT) begin
      rd_entry = mem_q[rd_addr];
    end
  end

endmodule

// File: rtl/cr_var_ram.sv
module cr_var_ram #(
  parameter int DEPTH  = 176,
  parameter int ADDR_W = 11,
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  cr_pkg::wsel_e     wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              frame_start,
  input  logic              consume,
  output cr_pkg::cell_t     rd_cell,
  output logic              exhausted,
  output logic [SLOT_W-1:0] slot_cnt
);
  localparam logic [ADDR_W-1:0] LIMIT    = ADDR_W'(DEPTH);
  localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(DEPTH);

  cr_pkg::cell_t     mem_q [DEPTH];
  logic              we;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_d;
  logic              slot_en;

  assign we = wr_en && (wr_sel == cr_pkg::WSEL_RAM) && (wr_addr < LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= '0;
      end
    end else if (we) begin
      mem_q[wr_addr] <= cr_pkg::cell_t'(wr_data);
    end
  end

  // slot sequencer: frame restart wins over an advance in the same cycle
  assign exhausted = (slot_q == SLOT_END);

  always_comb begin
    slot_en = 1'b0;
    slot_d  = slot_q;
    if (frame_start) begin
      slot_en = 1'b1;
      slot_d  = '0;
    end else if (consume && !exhausted) begin
      slot_en = 1'b1;
      slot_d  = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (slot_en) begin
      slot_q <= slot_d;
    end
  end

  always_comb begin
    rd_cell = '0;
    if (!exhausted) begin
      rd_cell = mem_q[slot_q];
    end
  end

  assign slot_cnt = slot_q;

endmodule

// File: rtl/cr_code_resolver.sv
module cr_code_resolver #(
  parameter int          ROWS       = 12,
  parameter int          COLS       = 24,
  parameter int          LINES      = 64,
  parameter int          RAM_DEPTH  = 176,
  parameter logic [6:0]  BLANK_CODE = 7'h20,
  localparam int         TBL_DEPTH  = LINES * COLS,
  localparam int         ADDR_W     = $clog2(TBL_DEPTH),
  localparam int         ROW_W      = $clog2(ROWS),
  localparam int         COL_W      = $clog2(COLS),
  localparam int         SLOT_W     = $clog2(RAM_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              frame_start,
  input  logic              req_valid,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              out_valid,
  output logic [6:0]        out_code,
  output logic              out_attr
);
  import cr_pkg::*;

  localparam logic [ROW_W-1:0] ROW_LIM = ROW_W'(ROWS);
  localparam logic [COL_W-1:0] COL_LIM = COL_W'(COLS);
  localparam logic [ADDR_W:0]  TBL_END = (ADDR_W+1)'(TBL_DEPTH);

  // reset: asserted at once, released two clocks later
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q = rst_pipe[1];

  wsel_e sel;
  assign sel = wsel_e'(wr_sel);

  // ---------------- stage 1: bounds check and table address
  logic              row_ok;
  logic              col_ok;
  logic              req_ok;
  logic [ADDR_W:0]   sum_addr;
  logic              s1_vld_q;
  logic              s1_vld_d;
  logic [ADDR_W:0]   s1_addr_q;

  assign row_ok   = req_row < ROW_LIM;
  assign col_ok   = req_col < COL_LIM;
  assign req_ok   = req_valid && row_ok && col_ok;
  assign s1_vld_d = req_ok;

  cr_ptr_bank #(
    .ROWS  (ROWS),
    .ADDR_W(ADDR_W),
    .ROW_W (ROW_W),
    .COL_W (COL_W)
  ) u_ptr (
    .clk    (clk),
    .rst_n  (rst_q),
    .wr_en  (wr_en),
    .wr_sel (sel),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .row_ok (row_ok),
    .rd_row (req_row),
    .rd_col (req_col),
    .rd_addr(sum_addr)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= s1_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_addr_q <= '0;
    end else if (req_ok) begin
      s1_addr_q <= sum_addr;
    end
  end

  // ---------------- stage 2: source select
  entry_t            entry;
  cell_t             ram_cell;
  logic              exhausted;
  logic              in_tbl;
  logic              redirect;
  logic              consume;
  logic [SLOT_W-1:0] slot_cnt;

  assign in_tbl   = s1_addr_q < TBL_END;
  assign redirect = s1_vld_q && in_tbl && entry.redir;
  assign consume  = redirect && !exhausted;

  cr_line_table #(
    .DEPTH (TBL_DEPTH),
    .ADDR_W(ADDR_W)
  ) u_tbl (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_en   (wr_en),
    .wr_sel  (sel),
    .wr_addr (wr_addr),
    .wr_data (wr_data[7:0]),
    .rd_addr (s1_addr_q[ADDR_W-1:0]),
    .rd_entry(entry)
  );

  cr_var_ram #(
    .DEPTH (RAM_DEPTH),
    .ADDR_W(ADDR_W),
    .SLOT_W(SLOT_W)
  ) u_ram (
    .clk        (clk),
    .rst_n      (rst_q),
    .wr_en      (wr_en),
    .wr_sel     (sel),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data[7:0]),
    .frame_start(frame_start),
    .consume    (consume),
    .rd_cell    (ram_cell),
    .exhausted  (exhausted),
    .slot_cnt   (slot_cnt)
  );

  cell_t res_d;
  cell_t res_q;
  logic  vld_q;

  always_comb begin
    res_d = '{attr: 1'b0, code: BLANK_CODE};
    if (in_tbl) begin
      if (!entry.redir) begin
        res_d = '{attr: 1'b0, code: entry.code};
      end else if (!exhausted) begin
        res_d = ram_cell;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= s1_vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      res_q <= '0;
    end else if (s1_vld_q) begin
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign out_code  = res_q.code;
  assign out_attr  = res_q.attr;

endmodule

// File: rtl/cr_checker.sv
module cr_checker #(
  parameter int ROWS      = 12,
  parameter int COLS      = 24,
  parameter int RAM_DEPTH = 176,
  parameter int ROW_W     = 4,
  parameter int COL_W     = 5,
  parameter int SLOT_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ROW_W-1:0]  req_row,
  input logic [COL_W-1:0]  req_col,
  input logic              frame_start,
  input logic              out_valid,
  input logic [SLOT_W-1:0] slot_cnt
);
  logic req_ok;
  assign req_ok = req_valid && (req_row < ROW_W'(ROWS)) && (req_col < COL_W'(COLS));

  // R8: in-range request yields a result two cycles later
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok |=> ##1 out_valid);

  // R8: no result without an in-range request two cycles earlier
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(req_ok, 2));

  // R6: frame restart clears the slot sequence
  a_r6_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (slot_cnt == '0));

  // R7: slot count never passes the RAM size
  a_r7_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cnt <= SLOT_W'(RAM_DEPTH));

  // R5: slots advance by at most one per cycle
  a_r5_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |->
      ((slot_cnt == $past(slot_cnt)) || (slot_cnt == $past(slot_cnt) + 1'b1)));

  // R10: a slot is only used by a cell that produces a result
  a_r10_slot_with_output: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frame_start) && (slot_cnt != $past(slot_cnt))) |-> out_valid);

endmodule

bind cr_code_resolver cr_checker #(
  .ROWS     (ROWS),
  .COLS     (COLS),
  .RAM_DEPTH(RAM_DEPTH),
  .ROW_W    (ROW_W),
  .COL_W    (COL_W),
  .SLOT_W   (SLOT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .req_valid  (req_valid),
  .req_row    (req_row),
  .req_col    (req_col),
  .frame_start(frame_start),
  .out_valid  (out_valid),
  .slot_cnt   (slot_cnt)
);

// File: tb/sim_cr_code_resolver.sv
module sim_cr_code_resolver;
  localparam int NROW = 12;
  localparam int NCOL = 24;
  localparam int NTBL = 1536;
  localparam int NRAM = 176;
  localparam logic [6:0] BLANK = 7'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [10:0] wr_addr = '0;
  logic [10:0] wr_data = '0;
  logic        frame_start = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_row = '0;
  logic [4:0]  req_col = '0;
  logic        out_valid;
  logic [6:0]  out_code;
  logic        out_attr;

  always #10 clk = ~clk;

  cr_code_resolver u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .frame_start(frame_start),
    .req_valid(req_valid), .req_row(req_row), .req_col(req_col),
    .out_valid(out_valid), .out_code(out_code), .out_attr(out_attr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  tbl_m [NTBL];
  logic [7:0]  ram_m [NRAM];
  logic [10:0] ptr_m [NROW];
  int          slot_m;

  task automatic wr(input int sel, input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_addr = 11'(addr); wr_data = 11'(data);
    @(negedge clk);
    wr_en = 1'b0;
    // R2 model of the write port
    if (sel == 0 && addr < NTBL) tbl_m[addr] = 8'(data);
    if (sel == 1 && addr < NRAM) ram_m[addr] = 8'(data);
    if (sel == 2 && addr < NROW) ptr_m[addr] = 11'(data);
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    slot_m = 0;
  endtask

  task automatic chk(input string tag, input logic v, input logic [6:0] c, input logic a,
                     input logic ev, input logic [6:0] ec, input logic ea);
    checks++;
    if (v !== ev || (ev && (c !== ec || a !== ea))) begin
      errors++;
      $display("FAIL %s: got valid=%b code=%h attr=%b, expected valid=%b code=%h attr=%b",
               tag, v, c, a, ev, ec, ea);
    end
  endtask

  // drive one request, sample two edges later
  task automatic req(input int row, input int col, input string tag);
    logic ev; logic [6:0] ec; logic ea; int addr;
    ev = (row < NROW) && (col < NCOL);          // R8
    ec = BLANK; ea = 1'b0;
    if (ev) begin
      addr = int'(ptr_m[row]) + col;            // R3
      if (addr < NTBL) begin                    // R9 otherwise
        if (!tbl_m[addr][7]) begin              // R4 / R10
          ec = tbl_m[addr][6:0];
        end else if (slot_m < NRAM) begin       // R5
          ec = ram_m[slot_m][6:0]; ea = ram_m[slot_m][7]; slot_m++;
        end                                     // R7 blank
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_row = 4'(row); req_col = 5'(col);
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b0 && ev) begin
      errors++;
      $display("FAIL R8 early: got valid=%b expected 0", out_valid);
    end
    @(negedge clk);
    chk(tag, out_valid, out_code, out_attr, ev, ec, ea);
  endtask

  task automatic full_frame(input string tag);
    frame();
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++)
        req(r, c, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NTBL; i++) tbl_m[i] = '0;
    for (int i = 0; i < NRAM; i++) ram_m[i] = '0;
    for (int i = 0; i < NROW; i++) ptr_m[i] = '0;
    slot_m = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 idle", out_valid, out_code, out_attr, 1'b0, 7'h0, 1'b0);
    req(0, 0, "R1 cleared entry");

    // R2 ignored writes: table[0] stays direct 0x11
    wr(0, 0, 8'h11);
    wr(3, 0, 8'h55);
    @(negedge clk); wr_en = 1'b0; wr_sel = 2'd0; wr_addr = 11'd0; wr_data = 11'h66;
    @(negedge clk);
    req(0, 0, "R2 ignored write");

    // random contents
    for (int i = 0; i < NTBL; i++)
      wr(0, i, ($urandom % 4 == 0) ? 8'h80 : ($urandom % 128));
    for (int i = 0; i < NRAM; i++) wr(1, i, $urandom % 256);
    for (int r = 0; r < NROW; r++) wr(2, r, 24 * ($urandom % 64));

    full_frame("R3 R4 R5 random frame");
    full_frame("R6 repeated frame");

    // R3 boundary lines: line 2 and line 64
    wr(2, 0, 24); wr(2, 1, 1512);
    frame();
    req(0, 0, "R3 line 2 first"); req(1, 23, "R3 line 64 last");

    // R7 exhaustion: last line all redirect, every row points at it
    for (int c = 0; c < NCOL; c++) wr(0, 1512 + c, 8'h80);
    for (int r = 0; r < NROW; r++) wr(2, r, 1512);
    full_frame("R7 exhaustion frame");

    // R6 restart after exhaustion
    frame();
    req(0, 0, "R6 slot 0 after restart");

    // R9 beyond table end, R8 out-of-range requests
    wr(2, 3, 1530);
    req(3, 5, "R9 last table entry");
    req(3, 10, "R9 beyond table");
    req(12, 0, "R8 row out of range");
    req(0, 24, "R8 col out of range");
    req(0, 1, "R10 R5 next slot after ignored cells");

    // random requests, including out-of-range
    wr(2, 5, 0);
    frame();
    for (int i = 0; i < 400; i++)
      req($urandom % 16, $urandom % 32, "R8 R4 R5 random request");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule